// File: doc/BRIEF.md
# Second-Order Fixed-Point Allpass Section

This block filters a stream of 20-bit two's complement samples through a recursive second-order allpass section with transfer function (c + z^-2)/(1 + c z^-2). Its poles and zeros sit on the imaginary axis, with each zero at the reciprocal radius of its pole. Only even powers of z^-1 appear, so each sample interacts only with the sample two positions earlier. The section is the basic stage of two-path half-band and decimation filters. Each path of such a filter uses one section with its own coefficient.

The numerator is computed first: y[n] = x[n-2] + c*(x[n] - y[n-2]). There is no hardware multiplier. The coefficient is fixed at elaboration to 0.125 or 0.5625 and is applied with shifts and one add. Each arithmetic step has its own rounding rule. The difference wraps at 20 bits. The product is kept exactly with four extra fraction bits. The final sum drops those bits, rounding toward zero, which avoids limit cycles and keeps the DC offset small. Any other coefficient value stops elaboration with an error.

Each accepted input produces one output on the following cycle. A synchronous clear empties the history without a full reset.

Top module: `ap2_allpass_section`

## Requirements
- R1: After reset, and on the cycle after any clear, out_valid is 0 and out_sample is 0, and all four history registers hold zero.
- R2: out_valid is 1 in exactly the cycles that follow a cycle with in_valid high and clear low. In every other cycle out_sample keeps its previous value.
- R3: Cycles with in_valid low change no state. The recursion x[n-2], y[n-2] counts accepted samples only, not clock cycles.
- R4: The difference x[n] - y[n-2] is formed modulo 2^20 and read as a signed 20-bit value. A result beyond the 20-bit range wraps.
- R5: With COEF_SIXTEENTHS = 2 (c = 0.125), the product equals the difference times 2 in units of 2^-4 sample LSB, with no loss.
- R6: With COEF_SIXTEENTHS = 9 (c = 0.5625), the product equals the difference times 9 in units of 2^-4 sample LSB, with no loss.
- R7: The output equals (16*x[n-2] + product) divided by 16 with rounding toward zero, then wrapped to 20 bits. The result is therefore never larger in magnitude than the exact value.
- R8: Clear takes priority over in_valid. A sample presented together with clear is discarded, and the next accepted sample sees zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the sample history |
| in_valid | input | 1 | Marks in_sample as a new sample |
| in_sample | input | 20 | Input sample, two's complement |
| out_valid | output | 1 | Marks out_sample as a new result |
| out_sample | output | 20 | Filtered sample, two's complement |

## Verification
The assertions assume that in_valid and clr are single-cycle qualifiers sampled at each rising edge. They place no limits on the sample values, because every wrap and rounding case is defined.

The stimulus drives inputs only on falling edges. It covers the following cases:
- full-scale positive and negative inputs that force the difference to wrap;
- negative sums with nonzero discarded bits, which exercise rounding toward zero;
- random gaps between samples;
- one clear with in_valid high.

Two instances, one for each coefficient, receive the same input stream.

// File: rtl/ap2_pkg.sv
package ap2_pkg;

    localparam int SAMPLE_W = 20;
    localparam int GUARD_W  = 4;
    localparam int HIST_D   = 2;

    localparam int COEF_EIGHTH       = 2;
    localparam int COEF_NINE_SIXTEEN = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAKE  = 2'd1,
        ST_FLUSH = 2'd2
    } step_e;

    typedef struct packed {
        logic                       vld;
        logic signed [SAMPLE_W-1:0] data;
    } beat_t;

    function automatic logic signed [SAMPLE_W-1:0] sub_wrap(
        input logic signed [SAMPLE_W-1:0] a,
        input logic signed [SAMPLE_W-1:0] b
    );
        logic signed [SAMPLE_W-1:0] nb;
        nb = ~b;
        return a + nb + SAMPLE_W'(1);
    endfunction

    function automatic step_e classify(input logic clear, input logic take);
        if (clear)     return ST_FLUSH;
        else if (take) return ST_TAKE;
        else           return ST_IDLE;
    endfunction

endpackage

// File: rtl/ap2_delay_pair.sv
module ap2_delay_pair #(
    parameter int W     = ap2_pkg::SAMPLE_W,
    parameter int DEPTH = ap2_pkg::HIST_D
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      shift,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);

    logic [W-1:0] stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clr)  stage_q[i] <= '0;
                else if (shift)  stage_q[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || clr)  stage_q[i] <= '0;
                else if (shift)  stage_q[i] <= stage_q[i-1];
            end

            // R3
            shift_chk: assert property (@(posedge clk) disable iff (rst)
                (shift && !clr) |=> stage_q[i] == $past(stage_q[i-1]));

            // R3
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!shift && !clr) |=> $stable(stage_q[i]));
        end
        assign taps[i] = stage_q[i];
    end

endmodule

// File: rtl/ap2_coef_mult.sv
module ap2_coef_mult #(
    parameter int COEF_SIXTEENTHS = ap2_pkg::COEF_EIGHTH,
    parameter int W               = ap2_pkg::SAMPLE_W,
    parameter int GUARD_W         = ap2_pkg::GUARD_W,
    localparam int PW             = W + GUARD_W
) (
    input  logic signed [W-1:0]  diff,
    output logic signed [PW-1:0] prod
);

    logic signed [PW-1:0] ext;
    assign ext = {{GUARD_W{diff[W-1]}}, diff};

    if (GUARD_W < 4) begin : g_bad_guard
        $error("ap2_coef_mult: GUARD_W must be at least 4");
    end

    if (COEF_SIXTEENTHS == ap2_pkg::COEF_EIGHTH) begin : g_eighth
        // 1/8 : shift right by three, rescaled to GUARD_W extra fraction bits
        assign prod = ext <<< (GUARD_W - 3);
    end else if (COEF_SIXTEENTHS == ap2_pkg::COEF_NINE_SIXTEEN) begin : g_nine
        // 9/16 : one half plus one sixteenth
        assign prod = (ext <<< (GUARD_W - 1)) + (ext <<< (GUARD_W - 4));
    end else begin : g_unsupported
        $error("ap2_coef_mult: COEF_SIXTEENTHS must be 2 or 9");
        assign prod = '0;
    end

    always_comb begin
        // R5 R6
        sign_chk: assert ((diff == '0) ? (prod == '0) : (prod[PW-1] == diff[W-1]));
    end

endmodule

// File: rtl/ap2_rtz_adder.sv
module ap2_rtz_adder #(
    parameter int W       = ap2_pkg::SAMPLE_W,
    parameter int GUARD_W = ap2_pkg::GUARD_W,
    localparam int PW     = W + GUARD_W,
    localparam int SW     = PW + 1
) (
    input  logic signed [W-1:0]  base,
    input  logic signed [PW-1:0] prod,
    output logic signed [W-1:0]  result
);

    logic signed [SW-1:0] sum_w;
    logic signed [SW-1:0] floor_w;
    logic signed [SW-1:0] rtz_w;
    logic signed [SW-1:0] back_w;
    logic                 bump;

    assign sum_w   = {base[W-1], base, {GUARD_W{1'b0}}} + {prod[PW-1], prod};
    assign floor_w = sum_w >>> GUARD_W;
    assign bump    = sum_w[SW-1] && (|sum_w[GUARD_W-1:0]);
    assign rtz_w   = floor_w + {{(SW-1){1'b0}}, bump};
    assign back_w  = rtz_w <<< GUARD_W;
    assign result  = rtz_w[W-1:0];

    always_comb begin
        // R7
        rtz_mag_chk: assert ((sum_w >= 0) ? (back_w <= sum_w && sum_w - back_w < (SW'(1) <<< GUARD_W))
                                           : (back_w >= sum_w && back_w - sum_w < (SW'(1) <<< GUARD_W)));
    end

endmodule

// File: rtl/ap2_allpass_section.sv
module ap2_allpass_section #(
    parameter int COEF_SIXTEENTHS = ap2_pkg::COEF_EIGHTH,
    parameter int SAMPLE_W        = ap2_pkg::SAMPLE_W,
    parameter int GUARD_W         = ap2_pkg::GUARD_W,
    localparam int PW             = SAMPLE_W + GUARD_W,
    localparam int HD             = ap2_pkg::HIST_D
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    import ap2_pkg::*;

    logic [HD-1:0][SAMPLE_W-1:0] x_taps;
    logic [HD-1:0][SAMPLE_W-1:0] y_taps;
    logic signed [SAMPLE_W-1:0]  diff;
    logic signed [PW-1:0]        prod;
    logic signed [SAMPLE_W-1:0]  y_new;
    step_e                       step;
    logic                        take;

    assign step = classify(clr, in_valid);
    assign take = (step == ST_TAKE);

    ap2_delay_pair #(.W(SAMPLE_W), .DEPTH(HD)) u_x_hist (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .shift(take),
        .din  (in_sample),
        .taps (x_taps)
    );

    // the difference wraps at the sample width
    assign diff = sub_wrap(SAMPLE_W'(in_sample), SAMPLE_W'(y_taps[HD-1]));

    ap2_coef_mult #(
        .COEF_SIXTEENTHS(COEF_SIXTEENTHS),
        .W              (SAMPLE_W),
        .GUARD_W        (GUARD_W)
    ) u_mult (
        .diff(diff),
        .prod(prod)
    );

    ap2_rtz_adder #(.W(SAMPLE_W), .GUARD_W(GUARD_W)) u_add (
        .base  (SAMPLE_W'(x_taps[HD-1])),
        .prod  (prod),
        .result(y_new)
    );

    ap2_delay_pair #(.W(SAMPLE_W), .DEPTH(HD)) u_y_hist (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .shift(take),
        .din  (y_new),
        .taps (y_taps)
    );

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= take;
    end

    assign out_sample = y_taps[0];

    // R2
    out_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clr) |=> out_valid);

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> ($stable(out_sample) && !out_valid));

    // R8
    clr_flush_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (out_sample == '0 && !out_valid));

    // R1
    rst_zero_chk: assert property (@(posedge clk)
        rst |=> (out_sample == '0 && !out_valid));

endmodule

// File: tb/test_ap2_allpass_section.sv
module test_ap2_allpass_section;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic         ova, ovb;
    logic [W-1:0] osa, osb;

    int n_cmp = 0;
    int n_bad = 0;

    int exp_a[$];
    int exp_b[$];
    int last_a = 0, last_b = 0;

    // model history: [0] newest, [1] older
    int xa1 = 0, xa2 = 0, ya1 = 0, ya2 = 0;
    int xb1 = 0, xb2 = 0, yb1 = 0, yb2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ap2_allpass_section #(.COEF_SIXTEENTHS(2)) i_ap2_allpass_section (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ova), .out_sample(osa)
    );

    ap2_allpass_section #(.COEF_SIXTEENTHS(9)) i_ap2_allpass_section_nine (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ovb), .out_sample(osb)
    );

    function automatic int wrap20(longint v);
        longint m;
        m = v & 64'hFFFFF;
        if (m >= 524288) m = m - 1048576;
        return int'(m);
    endfunction

    // R4 wrap of difference, R5/R6 exact product, R7 rounding toward zero
    function automatic int model(int x, int x2, int y2, int c16);
        int d;
        longint s;
        d = wrap20(longint'(x) - longint'(y2));
        s = longint'(x2) * 16 + longint'(d) * c16;
        return wrap20(s / 16);
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(int x);
        int ya, yb;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x[W-1:0];
        ya = model(x, xa2, ya2, 2);
        yb = model(x, xb2, yb2, 9);
        exp_a.push_back(ya);
        exp_b.push_back(yb);
        xa2 = xa1; xa1 = x; ya2 = ya1; ya1 = ya;
        xb2 = xb1; xb1 = x; yb2 = yb1; yb1 = yb;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_sample = $urandom;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    // R8: clear with a sample present discards it
    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        in_valid = 1'b1;
        in_sample = 20'h12345;
        xa1 = 0; xa2 = 0; ya1 = 0; ya2 = 0;
        xb1 = 0; xb2 = 0; yb1 = 0; yb2 = 0;
        @(negedge clk);
        clr = 1'b0;
        in_valid = 1'b0;
    endtask

    // scoreboard monitor, a quarter period after each rising edge
    always @(posedge clk) begin
        logic flush;
        flush = rst || clr;
        #(CLK_PERIOD/4);
        if (flush) begin
            // R1 zero state after reset or clear
            check("R1 out_sample", int'($signed(osa)), 0);
            check("R1 out_valid", int'(ova) + int'(ovb), 0);
            check("R1 out_sample nine", int'($signed(osb)), 0);
            last_a = 0; last_b = 0;
        end else begin
            if (ova) begin
                if (exp_a.size() == 0) check("R2 unexpected out_valid", 1, 0);
                else check("R3 R5 R7 coef 1/8", int'($signed(osa)), exp_a.pop_front());
                last_a = int'($signed(osa));
            end else begin
                check("R2 hold coef 1/8", int'($signed(osa)), last_a);
            end
            if (ovb) begin
                if (exp_b.size() == 0) check("R2 unexpected out_valid", 1, 0);
                else check("R3 R6 R7 coef 9/16", int'($signed(osb)), exp_b.pop_front());
                last_b = int'($signed(osb));
            end else begin
                check("R2 hold coef 9/16", int'($signed(osb)), last_b);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // impulse of 1.0 (2^17 LSB) then zeros: R3 R5 R6 R7
        send(1 << 17);
        for (int i = 0; i < 24; i++) send(0);
        idle(3);

        // step with gaps, R3 idle cycles do not advance history
        for (int i = 0; i < 20; i++) begin
            send(100000);
            if (i % 3 == 0) idle(2);
        end

        // full scale alternation forces the difference to wrap: R4
        for (int i = 0; i < 16; i++) begin
            send((i % 2 == 0) ? 524287 : -524288);
        end
        idle(2);

        // small negative values exercise rounding toward zero: R7
        for (int i = 0; i < 30; i++) send(-(i * 7 + 1));

        // clear with valid present: R8
        do_clear();
        send(5000);
        send(-3);
        send(77);
        idle(2);

        // random stream with random gaps
        for (int i = 0; i < 300; i++) begin
            send(wrap20(longint'($urandom)));
            if ($urandom % 3 == 0) idle(1 + ($urandom % 3));
        end
        idle(4);

        // R2: every accepted sample produced exactly one output
        check("R2 pending coef 1/8", exp_a.size(), 0);
        check("R2 pending coef 9/16", exp_b.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule